// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block is the serial configuration port of a larger chip. An external host reaches a small byte-wide register file over three pins: a serial clock, an active-low select and one data line. The data pad is bidirectional, and the block drives its data-out and output-enable pins. Every frame opens with a 16-bit instruction. The instruction holds the transfer direction, a 2-bit length code and a 13-bit start address, and it is followed by the data bytes. Fixed transfers of one, two or three bytes may be split by releasing select on a byte boundary. Streaming transfers run until select is released. While a multi-byte transfer runs, the address steps after every byte.

The three pins are sampled through synchronisers into the block's own clock, and all edge detection takes place in that clock domain. The register file is exported as a flat bus so that the rest of the chip can use the settings. Register 0 is the configuration byte. Its bit 0 selects least-significant-bit-first order for later frames. Its bit 5 is a self-clearing soft reset that returns every register to 0x00.

Top module: `spi3w_slave`

## Requirements
- R1: After rst_n the register bus reads all zero, spi_sdo_oe is low and the bit order is MSB-first.
- R2: Bits are taken on rising spi_sclk while spi_csn is low. The 16-bit instruction holds read/write in bit 15 (1 = read), the length code in bits 14:13 and the start address in bits 12:0. In MSB-first order bit 15 is sent first.
- R3: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 data bytes. After the last byte the next 16 bits are taken as a fresh instruction, even while spi_csn stays low.
- R4: Length code 11 keeps transferring bytes, read or write, until spi_csn goes high.
- R5: After each data byte the address moves down by one in MSB-first order and up by one in LSB-first order.
- R6: In a fixed-length transfer, raising spi_csn on a byte boundary pauses the frame. When spi_csn falls again, the next data byte follows with no new instruction.
- R7: Raising spi_csn while an instruction or data byte is only partly shifted discards it, leaves the registers unchanged and returns the block to waiting for an instruction. This holds in every mode.
- R8: On a read, spi_sdo_oe stays low through the instruction. It goes high for the data bytes, and each bit is presented after a falling spi_sclk edge, or after the falling spi_csn edge when a paused read resumes. The bit holds while spi_sclk is high. spi_sdo_oe is low within four clk cycles of spi_csn going high.
- R9: A written byte reaches its register only once its eighth bit has been taken. Registers never change at any other time.
- R10: Addresses at or above NREG (16) ignore writes and read back as 0x00.
- R11: Writing 1 to bit 0 of register 0 selects LSB-first order from the next instruction on. In that order the instruction is sent bit 0 first and each data byte is sent bit 0 first.
- R12: Writing register 0 with bit 5 set returns every register, register 0 included, to 0x00. Bit 5 never reads back as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select from the host |
| spi_sdi | input | 1 | Data pad input path |
| spi_sdo | output | 1 | Data pad output path (readback) |
| spi_sdo_oe | output | 1 | Output enable for the data pad |
| reg_bank_o | output | NREG*8 | Register file, register i in bits 8i+7:8i |

## Verification
The bench goes after the select-release cases. A pause between fixed-length bytes must resume without a new instruction; a design that aborted there would treat the resumed byte as an instruction, and the registers would be left unwritten. A release in the middle of a byte or instruction must lose the partial byte; a design that kept its bit counter would misalign every later frame. The bench checks that a register stays unchanged after seven bits, since a design that committed bits early would show partial values. It also checks the address direction in both bit orders and a read that runs past the implemented range, where a wrong step or a missing range check returns stale data. A paused readback is resumed, which catches a design that only drives data after a falling serial-clock edge: it would present a stale first bit.

// File: rtl/spi3w_pkg.sv
`timescale 1ns/1ps
package spi3w_pkg;
    localparam int INSTR_W    = 16;
    localparam int ADDR_W     = 13;
    localparam int INS_RW     = 15;
    localparam int INS_LEN_HI = 14;
    localparam int INS_LEN_LO = 13;

    localparam logic [1:0] LEN_STREAM = 2'b11;

    localparam int CFG_ADDR      = 0;
    localparam int CFG_LSB_FIRST = 0;
    localparam int CFG_SOFT_RST  = 5;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          bitcnt;
        logic [INSTR_W-1:0]  instr;
        logic                rd;
        logic [1:0]          len;
        logic [1:0]          left;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wbyte;
        logic                lsb;
        logic                sdo;
        logic                oe;
        logic                sclk_prev;
        logic                csn_prev;
    } eng_t;
endpackage

// File: rtl/spi3w_sync.sv
`timescale 1ns/1ps
module spi3w_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = STAGES'({chain_q, async_i[g]});
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi3w_regfile.sv
`timescale 1ns/1ps
module spi3w_regfile
    import spi3w_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [NREG*8-1:0] bank_o,
    output logic              lsb_first_o
);
    localparam int                IW    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NREG);

    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];
    logic       wr_hit, soft_rst;

    always_comb begin
        wr_hit   = wr_en_i && (wr_addr_i < LIMIT);
        soft_rst = wr_hit && (wr_addr_i == ADDR_W'(CFG_ADDR)) && wr_data_i[CFG_SOFT_RST];
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (soft_rst) begin
            for (int i = 0; i < NREG; i++) regs_d[i] = 8'h00;
        end else if (wr_hit) begin
            regs_d[wr_addr_i[IW-1:0]] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data_o   = (rd_addr_i < LIMIT) ? regs_q[rd_addr_i[IW-1:0]] : 8'h00;
    assign lsb_first_o = regs_q[CFG_ADDR][CFG_LSB_FIRST];

    for (genvar i = 0; i < NREG; i++) begin : g_bank
        assign bank_o[i*8 +: 8] = regs_q[i];
    end
endmodule

// File: rtl/spi3w_engine.sv
`timescale 1ns/1ps
module spi3w_engine
    import spi3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              sdi_i,
    input  logic              cfg_lsb_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              sdo_o,
    output logic              oe_o
);
    eng_t q, d;

    logic       sclk_rise, sclk_fall, csn_rise, csn_fall;
    logic       lsb_now;
    logic [3:0] ins_idx;
    logic [2:0] dat_idx;
    logic [2:0] out_idx;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        lsb_now   = q.lsb;
        ins_idx   = '0;
        dat_idx   = '0;
        out_idx   = q.lsb ? q.bitcnt[2:0] : (3'd7 - q.bitcnt[2:0]);

        sclk_rise = sclk_i & ~q.sclk_prev;
        sclk_fall = ~sclk_i & q.sclk_prev;
        csn_rise  = csn_i & ~q.csn_prev;
        csn_fall  = ~csn_i & q.csn_prev;

        d.sclk_prev = sclk_i;
        d.csn_prev  = csn_i;

        if (csn_i) begin
            d.oe = 1'b0;
            // a release is a pause only at a byte boundary of a fixed-length data phase
            if (csn_rise && (q.bitcnt != 4'd0 || q.phase == PH_INSTR || q.len == LEN_STREAM)) begin
                d.phase  = PH_INSTR;
                d.bitcnt = '0;
            end
        end else begin
            if (sclk_rise) begin
                if (q.phase == PH_INSTR) begin
                    if (q.bitcnt == 4'd0) begin
                        d.lsb   = cfg_lsb_i;
                        lsb_now = cfg_lsb_i;
                    end
                    ins_idx = lsb_now ? q.bitcnt : (4'd15 - q.bitcnt);
                    d.instr[ins_idx] = sdi_i;
                    if (q.bitcnt == 4'd15) begin
                        d.phase  = PH_DATA;
                        d.bitcnt = '0;
                        d.rd     = d.instr[INS_RW];
                        d.len    = d.instr[INS_LEN_HI:INS_LEN_LO];
                        d.left   = d.instr[INS_LEN_HI:INS_LEN_LO];
                        d.addr   = d.instr[ADDR_W-1:0];
                    end else begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                end else begin
                    dat_idx = q.lsb ? q.bitcnt[2:0] : (3'd7 - q.bitcnt[2:0]);
                    d.wbyte[dat_idx] = sdi_i;
                    if (q.bitcnt == 4'd7) begin
                        d.bitcnt = '0;
                        wr_en_o  = ~q.rd;
                        d.addr   = q.lsb ? (q.addr + 1'b1) : (q.addr - 1'b1);
                        if (q.len != LEN_STREAM) begin
                            if (q.left == 2'd0) d.phase = PH_INSTR;
                            else                d.left  = q.left - 2'd1;
                        end
                    end else begin
                        d.bitcnt = q.bitcnt + 4'd1;
                    end
                end
            end

            if ((sclk_fall || csn_fall) && q.phase == PH_DATA && q.rd) begin
                d.sdo = rd_data_i[out_idx];
                d.oe  = 1'b1;
            end

            if (d.phase == PH_INSTR) d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.csn_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o = q.addr;
    assign wr_addr_o = q.addr;
    assign wr_data_o = d.wbyte;
    assign sdo_o     = q.sdo;
    assign oe_o      = q.oe;
endmodule

// File: rtl/spi3w_slave.sv
`timescale 1ns/1ps
module spi3w_slave
    import spi3w_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [NREG*8-1:0] reg_bank_o
);
    logic              sclk_s, csn_s, sdi_s;
    logic [2:0]        pins_s;
    logic              cfg_lsb;
    logic [7:0]        rd_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_en;
    logic [7:0]        wr_data;

    spi3w_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sdi, spi_csn, spi_sclk}),
        .sync_o  (pins_s)
    );

    assign sclk_s = pins_s[0];
    assign csn_s  = pins_s[1];
    assign sdi_s  = pins_s[2];

    spi3w_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_s),
        .csn_i     (csn_s),
        .sdi_i     (sdi_s),
        .cfg_lsb_i (cfg_lsb),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .sdo_o     (spi_sdo),
        .oe_o      (spi_sdo_oe)
    );

    spi3w_regfile #(
        .NREG (NREG)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .bank_o      (reg_bank_o),
        .lsb_first_o (cfg_lsb)
    );
endmodule

// File: rtl/spi3w_slave_chk.sv
`timescale 1ns/1ps
module spi3w_slave_chk
    import spi3w_pkg::*;
#(
    parameter int NREG = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_s,
    input logic              csn_s,
    input logic              wr_en,
    input logic              spi_sdo,
    input logic              spi_sdo_oe,
    input logic [NREG*8-1:0] reg_bank_o
);
    AST_OE_DROPS_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !spi_sdo_oe); // R8

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe |-> !$past(csn_s)); // R8

    AST_SDO_HELD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !csn_s && !$past(csn_s)) |=> $stable(spi_sdo)); // R8

    AST_WRITE_ON_SCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!csn_s && $rose(sclk_s))); // R9

    AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !spi_sdo_oe); // R2

    AST_BANK_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(reg_bank_o)); // R9

    AST_SOFT_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_bank_o[CFG_ADDR*8 + CFG_SOFT_RST]); // R12
endmodule

bind spi3w_slave spi3w_slave_chk #(.NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sclk_s),
    .csn_s      (csn_s),
    .wr_en      (wr_en),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .reg_bank_o (reg_bank_o)
);

// File: tb/spi3w_slave_tb_top.sv
`timescale 1ns/1ps
module spi3w_slave_tb_top;
    localparam int NREG = 16;
    localparam int HALF = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic sdi = 1'b0;
    logic sdo, oe;
    logic [NREG*8-1:0] bank;

    always #5 clk = ~clk;

    spi3w_slave #(.NREG(NREG)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (sclk),
        .spi_csn    (csn),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_oe (oe),
        .reg_bank_o (bank)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NREG];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_q [$];
    bit         lsb_mode = 1'b0;
    bit         oe_bad = 1'b0;
    logic [7:0] junk;
    logic [7:0] mon_o, mon_e;
    string      mon_t;
    bit         done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_bank(input string tag);
        for (int i = 0; i < NREG; i++)
            chk(bank[i*8 +: 8] == model[i], tag, $sformatf("register %0d", i),
                32'(bank[i*8 +: 8]), 32'(model[i]));
    endtask

    task automatic mdl_wr(input int a, input logic [7:0] v);
        if (a < NREG) begin
            if (a == 0 && v[5]) begin
                for (int i = 0; i < NREG; i++) model[i] = 8'h00;
            end else begin
                model[a] = v;
            end
        end
    endtask

    task automatic shift_bit(input logic b, output logic r, input bit exp_oe);
        sdi = b;
        #HALF;
        sclk = 1'b1;
        r = sdo;
        if (oe !== exp_oe) oe_bad = 1'b1;
        #HALF;
        sclk = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] tx, input int nbits, input bit exp_oe,
                              output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            int   idx;
            logic r;
            idx = lsb_mode ? i : 7 - i;
            shift_bit(tx[idx], r, exp_oe);
            rx[idx] = r;
        end
    endtask

    task automatic send_instr(input bit rd, input logic [1:0] len, input logic [12:0] a);
        logic [15:0] w;
        logic [7:0]  x;
        w = {rd, len, a};
        if (lsb_mode) begin
            shift_byte(w[7:0], 8, 1'b0, x);
            shift_byte(w[15:8], 8, 1'b0, x);
        end else begin
            shift_byte(w[15:8], 8, 1'b0, x);
            shift_byte(w[7:0], 8, 1'b0, x);
        end
    endtask

    task automatic cs_low();
        csn = 1'b0;
        #HALF;
    endtask

    task automatic cs_high();
        #HALF;
        csn = 1'b1;
        #(2*HALF);
    endtask

    task automatic wr_byte(input logic [7:0] v);
        logic [7:0] x;
        shift_byte(v, 8, 1'b0, x);
    endtask

    // driver side of the scoreboard: push the expectation, then shift the byte
    task automatic rd_byte(input logic [7:0] e, input string tag);
        logic [7:0] rx;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        shift_byte(8'h00, 8, 1'b1, rx);
        obs_q.push_back(rx);
    endtask

    task automatic chk_oe(input string tag);
        chk(!oe_bad, tag, "pad direction during frame", 32'(oe_bad), 32'd0);
        oe_bad = 1'b0;
    endtask

    task automatic single_write(input logic [12:0] a, input logic [7:0] v);
        cs_low();
        send_instr(1'b0, 2'b00, a);
        wr_byte(v);
        cs_high();
        mdl_wr(int'(a), v);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                mon_o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected readback byte", 32'(mon_o), 32'd0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(mon_o == mon_e, mon_t, "readback byte", 32'(mon_o), 32'(mon_e));
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        #100;
        rst_n = 1'b1;
        #100;

        // R1: reset state
        chk(oe == 1'b0, "R1", "output enable after reset", 32'(oe), 32'd0);
        chk_bank("R1");
        cs_low();
        send_instr(1'b1, 2'b00, 13'd0);
        rd_byte(8'h00, "R1");
        cs_high();
        chk_oe("R8");
        chk(oe == 1'b0, "R8", "output enable after select release", 32'(oe), 32'd0);

        // R2: single write and read back
        single_write(13'd3, 8'h5A);
        chk_bank("R2");
        cs_low();
        send_instr(1'b1, 2'b00, 13'd3);
        rd_byte(8'h5A, "R2");
        cs_high();
        chk_oe("R2");

        // R3, R5: three-byte write, then a new instruction under the same select
        cs_low();
        send_instr(1'b0, 2'b10, 13'd9);
        wr_byte(8'h11);
        wr_byte(8'h22);
        wr_byte(8'h33);
        send_instr(1'b0, 2'b00, 13'd4);
        wr_byte(8'h44);
        cs_high();
        mdl_wr(9, 8'h11); mdl_wr(8, 8'h22); mdl_wr(7, 8'h33); mdl_wr(4, 8'h44);
        chk_bank("R3");
        chk(bank[7*8 +: 8] == 8'h33, "R5", "descending address", 32'(bank[7*8 +: 8]), 32'h33);
        chk_oe("R3");

        // R4: streaming write and read
        cs_low();
        send_instr(1'b0, 2'b11, 13'd15);
        for (int i = 0; i < 5; i++) begin
            wr_byte(8'hA0 + 8'(i));
            mdl_wr(15 - i, 8'hA0 + 8'(i));
        end
        cs_high();
        chk_bank("R4");
        cs_low();
        send_instr(1'b1, 2'b11, 13'd15);
        for (int i = 0; i < 5; i++) rd_byte(8'hA0 + 8'(i), "R4");
        cs_high();
        chk_oe("R4");

        // R6: paused write and paused read
        cs_low();
        send_instr(1'b0, 2'b01, 13'd6);
        wr_byte(8'h66);
        cs_high();
        cs_low();
        wr_byte(8'h55);
        cs_high();
        mdl_wr(6, 8'h66); mdl_wr(5, 8'h55);
        chk_bank("R6");
        cs_low();
        send_instr(1'b1, 2'b01, 13'd6);
        rd_byte(8'h66, "R6");
        cs_high();
        chk(oe == 1'b0, "R8", "output enable during pause", 32'(oe), 32'd0);
        cs_low();
        rd_byte(8'h55, "R6");
        cs_high();
        chk_oe("R6");

        // R9: write commits only on the eighth bit
        cs_low();
        send_instr(1'b0, 2'b00, 13'd2);
        shift_byte(8'hFF, 7, 1'b0, junk);
        chk(bank[2*8 +: 8] == 8'h00, "R9", "register after seven bits", 32'(bank[2*8 +: 8]), 32'h00);
        begin
            logic r;
            shift_bit(1'b1, r, 1'b0);
        end
        #40;
        chk(bank[2*8 +: 8] == 8'hFF, "R9", "register after eighth bit", 32'(bank[2*8 +: 8]), 32'hFF);
        cs_high();
        mdl_wr(2, 8'hFF);

        // R7: aborts mid data byte, mid instruction and mid stream
        cs_low();
        send_instr(1'b0, 2'b00, 13'd2);
        shift_byte(8'h00, 5, 1'b0, junk);
        cs_high();
        chk_bank("R7");
        single_write(13'd1, 8'h01);
        chk_bank("R7");
        cs_low();
        shift_byte(8'h0F, 8, 1'b0, junk);
        shift_byte(8'h00, 3, 1'b0, junk);
        cs_high();
        single_write(13'd10, 8'hC3);
        chk_bank("R7");
        cs_low();
        send_instr(1'b0, 2'b11, 13'd13);
        wr_byte(8'hD1);
        shift_byte(8'h00, 3, 1'b0, junk);
        cs_high();
        mdl_wr(13, 8'hD1);
        chk_bank("R7");

        // R10: addresses past the register file
        single_write(13'h100, 8'hEE);
        chk_bank("R10");
        cs_low();
        send_instr(1'b1, 2'b00, 13'h100);
        rd_byte(8'h00, "R10");
        cs_high();
        cs_low();
        send_instr(1'b1, 2'b01, 13'd16);
        rd_byte(8'h00, "R10");
        rd_byte(model[15], "R5");
        cs_high();
        chk_oe("R10");

        // R11: switch to LSB-first order, ascending addresses
        single_write(13'd0, 8'h01);
        chk_bank("R11");
        lsb_mode = 1'b1;
        cs_low();
        send_instr(1'b0, 2'b01, 13'd7);
        wr_byte(8'h7E);
        wr_byte(8'h81);
        cs_high();
        mdl_wr(7, 8'h7E); mdl_wr(8, 8'h81);
        chk_bank("R11");
        cs_low();
        send_instr(1'b1, 2'b01, 13'd7);
        rd_byte(8'h7E, "R11");
        rd_byte(8'h81, "R5");
        cs_high();
        chk_oe("R11");

        // R12: soft reset clears everything, order back to MSB-first
        cs_low();
        send_instr(1'b0, 2'b00, 13'd0);
        wr_byte(8'h21);
        cs_high();
        mdl_wr(0, 8'h21);
        lsb_mode = 1'b0;
        chk_bank("R12");
        cs_low();
        send_instr(1'b1, 2'b00, 13'd7);
        rd_byte(8'h00, "R12");
        cs_high();
        chk_oe("R12");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "unconsumed expectations", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        finish_run();
    end
endmodule